// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block sits between eight interrupt request inputs and a processor that takes an interrupt in two acknowledge strobes. A rising edge on any request input records a pending bit. The block resolves priority with a fixed order in which input 0 is highest. It raises an interrupt line when an unmasked pending request outranks everything already in service.

On the first acknowledge strobe, the winning request moves from the pending register into the in-service register. The block also latches the winner's index. Nothing is driven onto the data bus during this first strobe.

On the second strobe, the block places an 8-bit vector on the bus. The upper five bits come from a programmed base and the lower three from the latched index. In auto-EOI mode, the in-service bit is dropped when that strobe ends. Otherwise, an end-of-interrupt command clears the highest-priority in-service bit. The acknowledge strobe is a plain synchronous level sampled on the system clock. The sequencer moves forward on its edges and offers no back-pressure, so the vector is valid for exactly as long as the second strobe is high.

Top module: `irq_ack_sequencer`

## Requirements
- R1: A 0-to-1 transition on `irq_in[i]` sets bit i of `irr_out` one clock later. A line that stays high does not set the bit again after an acknowledge has cleared it.
- R2: `int_out` is 1 exactly when `irr_out & ~irq_mask` is non-zero and its lowest set index is lower than the lowest set index of `isr_out`, or `isr_out` is zero. Index 0 has the highest priority.
- R3: The first rising edge of `ack_in` from idle moves the highest-priority unmasked pending bit from `irr_out` to `isr_out`. Masked pending bits are left in `irr_out`.
- R4: `data_oe` is 0 while idle, during the first strobe, and between the two strobes. `data_out` is 0 whenever `data_oe` is 0.
- R5: During the second strobe, `data_oe` is 1 and `data_out` equals `{vec_base, index}`, where `vec_base` fills bits 7:3 and the 3-bit winning index fills bits 2:0.
- R6: The index is latched on the first strobe. New requests arriving between the two strobes do not change the vector.
- R7: With `auto_eoi`=1, the in-service bit of the winner clears on the clock where the second strobe falls. With `auto_eoi`=0, it stays set.
- R8: A one-cycle `eoi_cmd` clears only the lowest-index set bit of `isr_out`.
- R9: If no unmasked request is pending at the first strobe, `isr_out` is unchanged and the vector index is 7.
- R10: After the second strobe falls, the block is idle. `data_oe` is 0, and the next strobe is again treated as a first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines, rising edge recorded |
| irq_mask | input | 8 | 1 blocks a pending bit from winning |
| vec_base | input | 5 | Vector bits 7:3 |
| auto_eoi | input | 1 | 1 clears the in-service bit at the end of the second strobe |
| ack_in | input | 1 | Acknowledge strobe, active high |
| eoi_cmd | input | 1 | Non-specific end-of-interrupt pulse |
| int_out | output | 1 | Interrupt request to the processor |
| data_out | output | 8 | Vector bus, 0 when not enabled |
| data_oe | output | 1 | Bus drive enable |
| irr_out | output | 8 | Pending register |
| isr_out | output | 8 | In-service register |

## Verification
If the pending or in-service register is corrupted, the error shows on `int_out` in the same cycle. On the following acknowledge, it also shows in the vector's low three bits. If the sequencer state is wrong, `data_oe` is asserted on the wrong strobe, or it stays high after the strobe ends, and this is visible within one clock. The bench sweeps every request pattern under several masks, bases and both EOI modes. It compares the interrupt line, both registers and the vector against a lowest-set-bit model after every strobe edge.

// File: rtl/ivs_pkg.sv
`timescale 1ns/1ps
package ivs_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_FIRST  = 2'd1,
    SQ_GAP    = 2'd2,
    SQ_SECOND = 2'd3
  } seq_state_t;
endpackage

// File: rtl/ivs_req_latch.sv
`timescale 1ns/1ps
module ivs_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] irr
);
  logic [N-1:0] irq_prev;
  logic [N-1:0] rise;

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign rise[g] = irq_in[g] & ~irq_prev[g];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        irq_prev[g] <= 1'b0;
        irr[g]      <= 1'b0;
      end else begin
        irq_prev[g] <= irq_in[g];
        irr[g]      <= (irr[g] & ~clr_vec[g]) | rise[g];
      end
    end
  end

  // a fresh rising edge is always recorded
  assert_edge_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((irr & $past(rise)) == $past(rise)));
endmodule

// File: rtl/ivs_prio_pick.sv
`timescale 1ns/1ps
module ivs_prio_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/ivs_ack_fsm.sv
`timescale 1ns/1ps
module ivs_ack_fsm
  import ivs_pkg::*;
#(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_in,
  input  logic          auto_eoi,
  input  logic          req_any,
  input  logic [IW-1:0] req_idx,
  output logic          take_en,
  output logic          aeoi_clr_en,
  output logic [IW-1:0] win_idx,
  output logic          drive_en
);
  seq_state_t state;
  logic ack_q;
  logic win_real;
  logic ack_rise, ack_fall;

  assign ack_rise = ack_in & ~ack_q;
  assign ack_fall = ~ack_in & ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      ack_q    <= 1'b0;
      win_idx  <= '0;
      win_real <= 1'b0;
    end else begin
      ack_q <= ack_in;
      unique case (state)
        SQ_IDLE: if (ack_rise) begin
          state    <= SQ_FIRST;
          win_idx  <= req_any ? req_idx : '1;
          win_real <= req_any;
        end
        SQ_FIRST:  if (ack_fall) state <= SQ_GAP;
        SQ_GAP:    if (ack_rise) state <= SQ_SECOND;
        SQ_SECOND: if (ack_fall) state <= SQ_IDLE;
        default:   state <= SQ_IDLE;
      endcase
    end
  end

  assign take_en     = (state == SQ_IDLE) && ack_rise && req_any;
  assign aeoi_clr_en = (state == SQ_SECOND) && ack_fall && auto_eoi && win_real;
  assign drive_en    = (state == SQ_SECOND);

  // bus is only enabled after a complete first pulse and a gap
  assert_oe_after_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |-> ($past(state) == SQ_GAP));
  // latched index stays put while the bus is driven
  assert_idx_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && $past(drive_en)) |-> $stable(win_idx));
  // falling second strobe returns to idle
  assert_back_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && ack_fall) |=> !drive_en);
endmodule

// File: rtl/irq_ack_sequencer.sv
`timescale 1ns/1ps
module irq_ack_sequencer #(
  parameter int N_IRQ = 8,
  parameter int VEC_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [N_IRQ-1:0]                 irq_in,
  input  logic [N_IRQ-1:0]                 irq_mask,
  input  logic [VEC_W-$clog2(N_IRQ)-1:0]   vec_base,
  input  logic                             auto_eoi,
  input  logic                             ack_in,
  input  logic                             eoi_cmd,
  output logic                             int_out,
  output logic [VEC_W-1:0]                 data_out,
  output logic                             data_oe,
  output logic [N_IRQ-1:0]                 irr_out,
  output logic [N_IRQ-1:0]                 isr_out
);
  localparam int IW = $clog2(N_IRQ);

  logic [N_IRQ-1:0] irr, isr_q, clr_irr, set_isr, clr_isr, win_onehot, eoi_onehot;
  logic             req_any, isr_any, take_en, aeoi_clr_en, drive_en;
  logic [IW-1:0]    req_idx, isr_idx, win_idx;

  ivs_req_latch #(.N(N_IRQ)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr_vec(clr_irr), .irr(irr)
  );

  ivs_prio_pick #(.N(N_IRQ), .IW(IW)) u_req_pick (
    .vec(irr & ~irq_mask), .any(req_any), .idx(req_idx)
  );

  ivs_prio_pick #(.N(N_IRQ), .IW(IW)) u_isr_pick (
    .vec(isr_q), .any(isr_any), .idx(isr_idx)
  );

  ivs_ack_fsm #(.IW(IW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ack_in(ack_in), .auto_eoi(auto_eoi),
    .req_any(req_any), .req_idx(req_idx), .take_en(take_en),
    .aeoi_clr_en(aeoi_clr_en), .win_idx(win_idx), .drive_en(drive_en)
  );

  always_comb begin
    set_isr    = '0;
    win_onehot = '0;
    eoi_onehot = '0;
    set_isr[req_idx]    = take_en;
    win_onehot[win_idx] = 1'b1;
    eoi_onehot[isr_idx] = eoi_cmd & isr_any;
  end

  assign clr_irr = set_isr;
  assign clr_isr = (aeoi_clr_en ? win_onehot : '0) | eoi_onehot;

  always_ff @(posedge clk) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= (isr_q & ~clr_isr) | set_isr;
  end

  assign int_out  = req_any && (!isr_any || (req_idx < isr_idx));
  assign data_oe  = drive_en;
  assign data_out = drive_en ? {vec_base, win_idx} : '0;
  assign irr_out  = irr;
  assign isr_out  = isr_q;

  // interrupt only with an unmasked pending request
  assert_int_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr_out & ~irq_mask) != '0));
  // one in-service bit gained per accepted first strobe
  assert_take_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_en && !eoi_cmd) |=> ($countones(isr_q) == $countones($past(isr_q)) + 1));
  // auto-EOI drops the served bit
  assert_aeoi_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    aeoi_clr_en |=> ((isr_q & $past(win_onehot)) == '0));
  // EOI removes exactly one bit
  assert_eoi_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_cmd && isr_any && !take_en && !aeoi_clr_en) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1));
  // bus quiet unless enabled
  assert_bus_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == '0));
endmodule

// File: tb/sim_irq_ack_sequencer.sv
`timescale 1ns/1ps
module sim_irq_ack_sequencer;
  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] irq_in, irq_mask, data_out, irr_out, isr_out;
  logic [4:0] vec_base;
  logic auto_eoi, ack_in, eoi_cmd, int_out, data_oe;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_ack_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_mask(irq_mask),
    .vec_base(vec_base), .auto_eoi(auto_eoi), .ack_in(ack_in),
    .eoi_cmd(eoi_cmd), .int_out(int_out), .data_out(data_out),
    .data_oe(data_oe), .irr_out(irr_out), .isr_out(isr_out)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int low_bit(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  task automatic do_reset();
    rst_n = 0; irq_in = 0; ack_in = 0; eoi_cmd = 0;
    cyc(); cyc();
    rst_n = 1;
    cyc();
  endtask

  task automatic pulse_ack();
    ack_in = 1; cyc();
    ack_in = 0; cyc();
  endtask

  task automatic run_pattern(logic [7:0] p, logic [7:0] m, logic [4:0] b, logic ae);
    int w;
    logic [7:0] oh;
    do_reset();
    irq_mask = m; vec_base = b; auto_eoi = ae;
    irq_in = p; cyc();
    w = low_bit(p & ~m);
    oh = (w < 8) ? (8'd1 << w) : 8'd0;
    check("R1 irr after edge", irr_out, p);
    check("R2 int idle", int_out, (w < 8));
    ack_in = 1; cyc();
    check("R3 isr after first", isr_out, oh);
    check("R3 irr after first", irr_out, p & ~oh);
    check("R4 oe first", data_oe, 0);
    check("R2 int in service", int_out, 0);
    ack_in = 0; cyc();
    check("R4 oe gap", {data_oe, data_out}, 0);
    ack_in = 1; cyc();
    check("R5 vector", {data_oe, data_out}, {1'b1, b, (w < 8) ? w[2:0] : 3'd7});
    ack_in = 0; cyc();
    check("R10 idle oe", data_oe, 0);
    check("R7 isr after second", isr_out, ae ? 8'd0 : oh);
    if (!ae && w < 8) begin
      eoi_cmd = 1; cyc(); eoi_cmd = 0;
      check("R8 eoi clears", isr_out, 0);
    end
  endtask

  initial begin
    irq_mask = 0; vec_base = 5'd1; auto_eoi = 0;
    do_reset();
    check("R4 reset oe", {int_out, data_oe, data_out}, 0);
    check("R1 reset regs", {irr_out, isr_out}, 0);

    for (int p = 0; p < 256; p++) begin
      run_pattern(p[7:0], 8'h00, 5'h01, p[0]);
      run_pattern(p[7:0], 8'h0F, 5'h0E, p[1]);
      run_pattern(p[7:0], 8'hA5, p[4:0], p[2]);
    end

    // R9 spurious acknowledge with only masked requests
    run_pattern(8'h10, 8'h10, 5'h1F, 1'b0);
    check("R9 isr untouched", isr_out, 0);

    // R6 latched index, R2 nesting, R8 lowest clear, R1 held level
    do_reset();
    irq_mask = 0; vec_base = 5'h0E; auto_eoi = 0;
    irq_in = 8'h20; cyc();
    ack_in = 1; cyc(); ack_in = 0; cyc();
    irq_in = 8'h24; cyc();
    check("R2 higher request interrupts", int_out, 1);
    ack_in = 1; cyc();
    check("R6 vector kept", data_out, {5'h0E, 3'd5});
    ack_in = 0; cyc();
    check("R1 held line not reset", irr_out, 8'h04);
    ack_in = 1; cyc(); ack_in = 0; cyc();
    ack_in = 1; cyc();
    check("R5 nested vector", data_out, {5'h0E, 3'd2});
    ack_in = 0; cyc();
    check("R3 nested isr", isr_out, 8'h24);
    check("R1 level held stays clear", irr_out, 8'h00);
    eoi_cmd = 1; cyc(); eoi_cmd = 0;
    check("R8 lowest cleared", isr_out, 8'h20);
    eoi_cmd = 1; cyc(); eoi_cmd = 0;
    check("R8 second clear", isr_out, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule